// File: doc/BRIEF.md
# Guarded Predicate Flag File with Compare Slots

This block keeps a bank of one-bit condition flags that decide, instruction by instruction, whether a computed result is kept or thrown away. Each cycle it accepts up to two compare operations, one per issue slot. A compare checks two 64-bit operands for equality or inequality. It stores the outcome in one named flag and the inverse of the outcome in a second named flag. Each compare is itself guarded by a flag. A compare whose guard is clear does nothing, so a chain of nested if/else tests can be written as straight-line guarded code.

Two independent read ports look up the guard flag of any other instruction and return its keep (1) or discard (0) decision. Flag 0 is hard-wired to 1, so instructions that must always run name it as their guard. Every update lands on the next rising clock edge. Slot 0 is the earlier slot in program order and slot 1 the later, so slot 1 prevails when both slots write the same flag.

Top module: `pred_file`

## Requirements
- R1: Reset is synchronous and active low (`rst_n`). After a rising edge with `rst_n`=0, flags 1 to 63 all read 0.
- R2: Flag 0 always reads 1. A compare that names flag 0 as either destination leaves it at 1 but still writes its other destination.
- R3: An enabled compare writes its relation result to the flag named by `cmp_dst_t` and the inverse of that result to the flag named by `cmp_dst_f`. If both fields name the same flag, that flag ends with the inverse.
- R4: `cmp_ne`=0 selects equality and `cmp_ne`=1 selects inequality. Both relations compare all 64 bits, including bit 63.
- R5: Flag writes become visible on the edge that ends the cycle. A read in the same cycle, including the guard lookup of the other slot, returns the old value.
- R6: A compare whose guard flag reads 0 changes no flag. The same compare with a guard that reads 1 takes effect.
- R7: When both slots write the same flag in one cycle, the value from slot 1 (the later slot) is kept.
- R8: Each read port k returns on `rd_commit[k]` the current value of the flag indexed by `rd_qp[k]`, where 1 means commit and 0 means discard. The two ports work independently in the same cycle.
- R9: A slot with `cmp_valid` low changes no flag, whatever its other fields hold.

Slot k uses bits `[k*6 +: 6]` of every index bus and bits `[k*64 +: 64]` of every operand bus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_valid | input | 2 | Compare present in slot k |
| cmp_qp | input | 12 | Guard flag index per slot |
| cmp_a | input | 128 | First operand per slot |
| cmp_b | input | 128 | Second operand per slot |
| cmp_ne | input | 2 | Relation per slot: 0 equal, 1 not equal |
| cmp_dst_t | input | 12 | Destination for the result, per slot |
| cmp_dst_f | input | 12 | Destination for the inverse, per slot |
| rd_qp | input | 12 | Guard flag index per read port |
| rd_commit | output | 2 | Commit (1) or discard (0) per read port |

## Verification
On every cycle the assertions check the following:
- flag 0 reads 1 on both ports;
- reset clears the file;
- the file holds still when no slot is enabled;
- the later slot's two destinations end up complementary, and its true destination matches equality of its operands;
- the later slot prevails on a shared target.

Only the bench scenarios can show the rest:
- the stale same-cycle read, including one slot's guard missing the other slot's fresh write;
- the inverse winning when one compare names the same flag twice;
- bit-63 sensitivity of both relations;
- full if/else chains evaluated across several cycles.

// File: rtl/pred_pkg.sv
package pred_pkg;
    localparam int unsigned FLAG_COUNT = 64;
    localparam int unsigned OPND_W     = 64;
    localparam int unsigned SLOT_COUNT = 2;
    localparam int unsigned PORT_COUNT = 2;
endpackage

// File: rtl/pred_cmp_slot.sv
module pred_cmp_slot #(
    parameter int unsigned OPND_W = 64
) (
    input  logic              valid,
    input  logic              guard,
    input  logic [OPND_W-1:0] opnd_a,
    input  logic [OPND_W-1:0] opnd_b,
    input  logic              rel_ne,
    output logic              enable,
    output logic              result
);
    always_comb begin
        enable = valid & guard;
        if (rel_ne) result = (opnd_a != opnd_b);
        else        result = (opnd_a == opnd_b);
    end
endmodule

// File: rtl/pred_rd_port.sv
module pred_rd_port #(
    parameter int unsigned FLAG_COUNT = 64,
    localparam int unsigned IDX_W = $clog2(FLAG_COUNT)
) (
    input  logic [FLAG_COUNT-1:0] flags,
    input  logic [IDX_W-1:0]      idx,
    output logic                  value
);
    always_comb value = flags[idx];
endmodule

// File: rtl/pred_file.sv
module pred_file #(
    parameter int unsigned FLAG_COUNT = pred_pkg::FLAG_COUNT,
    parameter int unsigned OPND_W     = pred_pkg::OPND_W,
    parameter int unsigned SLOT_COUNT = pred_pkg::SLOT_COUNT,
    parameter int unsigned PORT_COUNT = pred_pkg::PORT_COUNT,
    localparam int unsigned IDX_W = $clog2(FLAG_COUNT)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [SLOT_COUNT-1:0]        cmp_valid,
    input  logic [SLOT_COUNT*IDX_W-1:0]  cmp_qp,
    input  logic [SLOT_COUNT*OPND_W-1:0] cmp_a,
    input  logic [SLOT_COUNT*OPND_W-1:0] cmp_b,
    input  logic [SLOT_COUNT-1:0]        cmp_ne,
    input  logic [SLOT_COUNT*IDX_W-1:0]  cmp_dst_t,
    input  logic [SLOT_COUNT*IDX_W-1:0]  cmp_dst_f,
    input  logic [PORT_COUNT*IDX_W-1:0]  rd_qp,
    output logic [PORT_COUNT-1:0]        rd_commit
);
    localparam logic [FLAG_COUNT-1:0] RESET_FLAGS = {{(FLAG_COUNT-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [FLAG_COUNT-1:0] flags;
    } file_state_t;

    file_state_t           state_d, state_q;
    logic [FLAG_COUNT-1:0] flags_q;
    logic [SLOT_COUNT-1:0] slot_guard;
    logic [SLOT_COUNT-1:0] slot_en;
    logic [SLOT_COUNT-1:0] slot_res;

    assign flags_q = state_q.flags;

    // per-slot guard lookup and relation evaluation
    for (genvar s = 0; s < SLOT_COUNT; s++) begin : g_slot
        pred_rd_port #(.FLAG_COUNT(FLAG_COUNT)) u_guard (
            .flags (flags_q),
            .idx   (cmp_qp[s*IDX_W +: IDX_W]),
            .value (slot_guard[s])
        );
        pred_cmp_slot #(.OPND_W(OPND_W)) u_cmp (
            .valid  (cmp_valid[s]),
            .guard  (slot_guard[s]),
            .opnd_a (cmp_a[s*OPND_W +: OPND_W]),
            .opnd_b (cmp_b[s*OPND_W +: OPND_W]),
            .rel_ne (cmp_ne[s]),
            .enable (slot_en[s]),
            .result (slot_res[s])
        );
    end

    // instruction commit lookups
    for (genvar p = 0; p < PORT_COUNT; p++) begin : g_port
        pred_rd_port #(.FLAG_COUNT(FLAG_COUNT)) u_rd (
            .flags (flags_q),
            .idx   (rd_qp[p*IDX_W +: IDX_W]),
            .value (rd_commit[p])
        );
    end

    // merge writes in program order: later slot overrides earlier
    always_comb begin
        logic [IDX_W-1:0] t_idx;
        logic [IDX_W-1:0] f_idx;
        state_d = state_q;
        for (int s = 0; s < SLOT_COUNT; s++) begin
            t_idx = cmp_dst_t[s*IDX_W +: IDX_W];
            f_idx = cmp_dst_f[s*IDX_W +: IDX_W];
            if (slot_en[s]) begin
                state_d.flags[t_idx] = slot_res[s];
                state_d.flags[f_idx] = ~slot_res[s];
            end
        end
        state_d.flags[0] = 1'b1;
        if (!rst_n) state_d.flags = RESET_FLAGS;
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end
endmodule

// File: rtl/pred_file_chk.sv
module pred_file_chk #(
    parameter int unsigned FLAG_COUNT = 64,
    parameter int unsigned OPND_W     = 64,
    parameter int unsigned SLOT_COUNT = 2,
    parameter int unsigned PORT_COUNT = 2,
    localparam int unsigned IDX_W = $clog2(FLAG_COUNT),
    localparam int unsigned LS = SLOT_COUNT - 1
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [SLOT_COUNT*OPND_W-1:0] cmp_a,
    input logic [SLOT_COUNT*OPND_W-1:0] cmp_b,
    input logic [SLOT_COUNT-1:0]        cmp_ne,
    input logic [SLOT_COUNT*IDX_W-1:0]  cmp_dst_t,
    input logic [SLOT_COUNT*IDX_W-1:0]  cmp_dst_f,
    input logic [PORT_COUNT*IDX_W-1:0]  rd_qp,
    input logic [PORT_COUNT-1:0]        rd_commit,
    input logic [SLOT_COUNT-1:0]        slot_en,
    input logic [SLOT_COUNT-1:0]        slot_res,
    input logic [FLAG_COUNT-1:0]        flags_q
);
    logic [IDX_W-1:0] last_t, last_f, first_t;
    assign last_t  = cmp_dst_t[LS*IDX_W +: IDX_W];
    assign last_f  = cmp_dst_f[LS*IDX_W +: IDX_W];
    assign first_t = cmp_dst_t[IDX_W-1:0];

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        !rst_n |=> flags_q == {{(FLAG_COUNT-1){1'b0}}, 1'b1});

    // R2
    flag0_port0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_qp[IDX_W-1:0] == '0 |-> rd_commit[0]);

    // R2
    flag0_port1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_qp[(PORT_COUNT-1)*IDX_W +: IDX_W] == '0 |-> rd_commit[PORT_COUNT-1]);

    // R6 R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en == '0 |=> flags_q == $past(flags_q));

    // R3
    pair_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[LS] && last_t != last_f && last_t != '0 && last_f != '0
        |=> flags_q[$past(last_t)] != flags_q[$past(last_f)]);

    // R4
    equal_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[LS] && !cmp_ne[LS] && last_t != '0 && last_t != last_f
        |=> flags_q[$past(last_t)] ==
            ($past(cmp_a[LS*OPND_W +: OPND_W]) == $past(cmp_b[LS*OPND_W +: OPND_W])));

    // R7
    later_slot_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en[0] && slot_en[LS] && first_t == last_t && last_t != '0 && last_t != last_f
        |=> flags_q[$past(last_t)] == $past(slot_res[LS]));
endmodule

bind pred_file pred_file_chk #(
    .FLAG_COUNT(FLAG_COUNT), .OPND_W(OPND_W),
    .SLOT_COUNT(SLOT_COUNT), .PORT_COUNT(PORT_COUNT)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmp_a     (cmp_a),
    .cmp_b     (cmp_b),
    .cmp_ne    (cmp_ne),
    .cmp_dst_t (cmp_dst_t),
    .cmp_dst_f (cmp_dst_f),
    .rd_qp     (rd_qp),
    .rd_commit (rd_commit),
    .slot_en   (slot_en),
    .slot_res  (slot_res),
    .flags_q   (flags_q)
);

// File: tb/pred_file_test.sv
module pred_file_test;
    localparam int IW = 6;
    localparam int W  = 64;
    localparam int S  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic [S-1:0]    cmp_valid;
    logic [S*IW-1:0] cmp_qp, cmp_dst_t, cmp_dst_f, rd_qp;
    logic [S*W-1:0]  cmp_a, cmp_b;
    logic [S-1:0]    cmp_ne, rd_commit;

    int errs = 0;
    int checks = 0;
    bit done = 0;

    pred_file uut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_qp(cmp_qp),
        .cmp_a(cmp_a), .cmp_b(cmp_b), .cmp_ne(cmp_ne), .cmp_dst_t(cmp_dst_t),
        .cmp_dst_f(cmp_dst_f), .rd_qp(rd_qp), .rd_commit(rd_commit)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic expect_flag(input string req, input int port, input int idx, input logic exp);
        rd_qp[port*IW +: IW] = idx[IW-1:0];
        #1;
        check($sformatf("%s flag %0d port %0d", req, idx, port), rd_commit[port], exp);
    endtask

    task automatic clear_slots();
        cmp_valid = '0; cmp_qp = '0; cmp_a = '0; cmp_b = '0;
        cmp_ne = '0; cmp_dst_t = '0; cmp_dst_f = '0;
    endtask

    task automatic set_slot(input int s, input int qp, input logic [W-1:0] a,
                            input logic [W-1:0] b, input logic ne, input int dt, input int df);
        cmp_valid[s] = 1'b1;
        cmp_qp[s*IW +: IW]    = qp[IW-1:0];
        cmp_a[s*W +: W]       = a;
        cmp_b[s*W +: W]       = b;
        cmp_ne[s]             = ne;
        cmp_dst_t[s*IW +: IW] = dt[IW-1:0];
        cmp_dst_f[s*IW +: IW] = df[IW-1:0];
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        clear_slots();
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        expect_flag("R2", 0, 0, 1'b1);
        expect_flag("R1", 0, 1, 1'b0);
        expect_flag("R1", 1, 37, 1'b0);
        expect_flag("R1", 0, 63, 1'b0);
    endtask

    task automatic t_relation();
        logic [W-1:0] v = 64'h8000_0000_0000_1234;
        set_slot(0, 0, v, v, 1'b0, 1, 2); tick();
        expect_flag("R3 R4 eq-match", 0, 1, 1'b1);
        expect_flag("R3 R4 eq-match", 0, 2, 1'b0);
        set_slot(0, 0, v, v, 1'b1, 3, 4); tick();
        expect_flag("R4 ne-match", 0, 3, 1'b0);
        expect_flag("R3 ne-match", 0, 4, 1'b1);
        set_slot(0, 0, v, v ^ 64'h8000_0000_0000_0000, 1'b0, 5, 6); tick();
        expect_flag("R4 eq-bit63", 0, 5, 1'b0);
        expect_flag("R3 eq-bit63", 0, 6, 1'b1);
        set_slot(0, 0, v, v ^ 64'h8000_0000_0000_0000, 1'b1, 7, 8); tick();
        expect_flag("R4 ne-bit63", 0, 7, 1'b1);
        expect_flag("R3 ne-bit63", 0, 8, 1'b0);
        set_slot(0, 0, v, v, 1'b0, 9, 9); tick();
        expect_flag("R3 same-dest inverse", 0, 9, 1'b0);
    endtask

    task automatic t_timing();
        set_slot(0, 0, 64'd3, 64'd3, 1'b0, 10, 11);
        expect_flag("R5 same-cycle old", 0, 10, 1'b0);
        tick();
        expect_flag("R5 after edge", 0, 10, 1'b1);
        set_slot(0, 0, 64'd1, 64'd1, 1'b0, 12, 13);
        set_slot(1, 12, 64'd1, 64'd1, 1'b0, 14, 15);
        tick();
        expect_flag("R5 slot0 write", 0, 12, 1'b1);
        expect_flag("R5 stale guard", 0, 14, 1'b0);
        expect_flag("R5 stale guard", 1, 15, 1'b0);
    endtask

    task automatic t_guard();
        set_slot(0, 2, 64'd4, 64'd4, 1'b0, 2, 1); tick();
        expect_flag("R6 guard off", 0, 1, 1'b1);
        expect_flag("R6 guard off", 1, 2, 1'b0);
        set_slot(0, 1, 64'd4, 64'd4, 1'b0, 2, 1); tick();
        expect_flag("R6 guard on", 0, 1, 1'b0);
        expect_flag("R6 guard on", 1, 2, 1'b1);
    endtask

    task automatic t_flag0();
        set_slot(0, 0, 64'd1, 64'd2, 1'b0, 0, 16); tick();
        expect_flag("R2 write zero", 0, 0, 1'b1);
        expect_flag("R2 other dest", 1, 16, 1'b1);
        set_slot(0, 0, 64'd5, 64'd5, 1'b0, 17, 0); tick();
        expect_flag("R2 inverse to 0", 0, 0, 1'b1);
        expect_flag("R2 other dest", 1, 17, 1'b1);
    endtask

    task automatic t_priority();
        set_slot(0, 0, 64'd8, 64'd8, 1'b0, 20, 21);
        set_slot(1, 0, 64'd8, 64'd9, 1'b0, 20, 22);
        tick();
        expect_flag("R7 later wins", 0, 20, 1'b0);
        expect_flag("R7 slot0 inverse", 0, 21, 1'b0);
        expect_flag("R7 slot1 inverse", 1, 22, 1'b1);
        set_slot(0, 0, 64'd1, 64'd2, 1'b0, 23, 24);
        set_slot(1, 0, 64'd1, 64'd2, 1'b0, 24, 25);
        tick();
        expect_flag("R7 slot0 true", 0, 23, 1'b0);
        expect_flag("R7 later wins inv-vs-res", 0, 24, 1'b0);
        expect_flag("R7 slot1 inverse", 1, 25, 1'b1);
    endtask

    task automatic t_valid();
        set_slot(0, 0, 64'd6, 64'd6, 1'b0, 26, 27);
        set_slot(1, 0, 64'd6, 64'd6, 1'b0, 28, 29);
        cmp_valid = '0;
        tick();
        expect_flag("R9 invalid slot0", 0, 26, 1'b0);
        expect_flag("R9 invalid slot1", 1, 28, 1'b0);
    endtask

    // if (a && b) j++; else if (c) k++; else k--;
    task automatic t_chain(input int base, input logic [W-1:0] a,
                           input logic [W-1:0] b, input logic [W-1:0] c,
                           input logic ej, input logic eki, input logic ekd);
        set_slot(0, 0, 64'd0, a, 1'b0, base, base + 1); tick();
        set_slot(0, base + 1, 64'd0, b, 1'b0, base, base + 2); tick();
        set_slot(0, base, 64'd0, c, 1'b1, base + 3, base + 4); tick();
        rd_qp[IW-1:0]    = base[IW-1:0] + 6'd2;
        rd_qp[IW +: IW]  = base[IW-1:0] + 6'd3;
        #1;
        check($sformatf("R8 R6 chain j base %0d", base), rd_commit[0], ej);
        check($sformatf("R8 R6 chain k+ base %0d", base), rd_commit[1], eki);
        expect_flag("R6 chain k-", 0, base + 4, ekd);
    endtask

    initial begin
        clear_slots();
        rd_qp = '0;
        t_reset();
        t_relation();
        t_timing();
        t_guard();
        t_flag0();
        t_priority();
        t_valid();
        t_chain(40, 64'd7, 64'd0, 64'd3, 1'b0, 1'b1, 1'b0);
        t_chain(45, 64'd7, 64'd5, 64'd3, 1'b1, 1'b0, 1'b0);
        t_chain(50, 64'd0, 64'd5, 64'd0, 1'b0, 1'b0, 1'b1);
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errs++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end
endmodule